// File: doc/BRIEF.md
# Multi-mode sample rate reducer

This block sits behind a converter sample stream that runs at a fixed rate. The stream delivers one signed sample per channel on each cycle where the input valid is high. The block lowers that rate by a programmable integer block length N and never touches the converter clock. The sample stream is split into blocks of N accepted samples. At the end of every block, each channel emits one result, which is built by the reduction mode that channel has selected. The mode can keep the last raw sample of the block, compute the block mean, or report the smallest and largest sample of the block as a pair.

All channels share one block counter. Each channel has its own accumulator, extreme-value trackers and a sequential divider that forms the mean. A second divider, shared by all channels, turns the block length into an effective output rate in tenths of a sample per second, so software can read the exact rate it obtained. A clear input restarts the block count and loads the requested length and modes at once. Outside a clear, new settings wait for the next block boundary.

Top module: `rate_reducer`

## Requirements
- R1: The block length is `divIn`, and a value of 0 acts as 1. Each channel produces exactly one result for every N accepted samples, where an accepted sample is a cycle with `inValid` high and `clear` low.
- R2: Mode code 0 (keep) puts the last sample of the block on both `outLo` and `outHi`. `outValid` for that channel is high in the cycle after the clock edge that accepted the last sample.
- R3: Mode code 1 (mean) puts the block sum divided by N, truncated toward zero, on both halves. When N is 1 the result has the same one-cycle timing as R2. When N is 2 or more, the result arrives through a sequential divider and is correct as long as N is at least SAMPLE_W+2.
- R4: Mode code 2 (extremes) puts the block minimum on `outLo` and the block maximum on `outHi` under a single strobe. The trackers restart from the first sample of each block.
- R5: Each channel takes its own 2-bit field of `modeIn` (channel c uses bits 2c+1:2c). Code 3 behaves like code 0.
- R6: A change to `divIn` or `modeIn` made in the middle of a block takes effect from the next block. A `clear` applies them immediately, discards the partial block, drops any sample offered in the same cycle, and forces `outValid` low in the following cycle.
- R7: Samples that arrive while a channel's divider is working go into the following block. None are lost.
- R8: If a channel produces a result while its previous result has not yet been taken (`outTake` bit low since that result), its `overflow` bit is set. The bit stays set until `clear`.
- R9: `rateDeciHz` equals floor(1,000,000,000 / N). It is updated within 40 cycles after a clear or after a boundary that changes N.
- R10: After reset, `outValid` and `overflow` are zero, N is 1, every mode is 0, and `rateDeciHz` is 1,000,000,000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Restart blocks and load settings now |
| divIn | input | DIV_W | Requested block length N |
| modeIn | input | 2*NUM_CH | Per-channel reduction mode codes |
| inValid | input | 1 | Sample strobe for all channels |
| inSample | input | NUM_CH*SAMPLE_W | Signed samples, channel 0 in the low bits |
| outTake | input | NUM_CH | Consumer has taken the channel's result |
| outValid | output | NUM_CH | Per-channel result strobe |
| outLo | output | NUM_CH*SAMPLE_W | Result, or block minimum |
| outHi | output | NUM_CH*SAMPLE_W | Result, or block maximum |
| overflow | output | NUM_CH | Sticky lost-result flag |
| rateDeciHz | output | DIV_W | Effective output rate in 0.1 sample/s |

## Verification
The assertions assume that reset is applied before the first edge. They also assume that a channel in mean mode never runs blocks shorter than SAMPLE_W+2 samples, because shorter blocks would hand the divider a new sum while it is still busy. The stimulus follows these assumptions. It only uses mean mode with N equal to 1 or N at least 16, and it switches modes only through `clear` or at boundaries that leave enough room. `outTake` stays high throughout, except in the one phase that provokes overflow on purpose.

// File: rtl/rr_pkg.sv
`timescale 1ns/1ps
package rr_pkg;
  localparam logic [1:0] MODE_KEEP    = 2'd0;
  localparam logic [1:0] MODE_MEAN    = 2'd1;
  localparam logic [1:0] MODE_EXTREME = 2'd2;

  typedef struct packed {
    logic clear;
    logic accept;
    logic first;
    logic last;
  } ctl_t;
endpackage

// File: rtl/rr_divider.sv
`timescale 1ns/1ps
// Restoring divider producing QW quotient bits; requires (dividend >> QW) < divisor.
module rr_divider #(
  parameter int ND = 42,
  parameter int NV = 30,
  parameter int QW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          abort,
  input  logic          start,
  input  logic [ND-1:0] dividend,
  input  logic [NV-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [QW-1:0] quotient
);
  localparam int RW = NV + 1;
  localparam int CW = $clog2(QW + 1);

  logic [RW-1:0] rem, shifted;
  logic [NV-1:0] dvs;
  logic [QW-1:0] quo;
  logic [CW-1:0] left;
  logic          fits;

  assign shifted  = {rem[NV-1:0], quo[QW-1]};
  assign fits     = shifted >= {1'b0, dvs};
  assign quotient = quo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rem <= '0; quo <= '0; dvs <= '0; left <= '0;
      busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
      end else if (start) begin
        rem  <= RW'(dividend >> QW);
        quo  <= dividend[QW-1:0];
        dvs  <= divisor;
        left <= CW'(QW);
        busy <= 1'b1;
      end else if (busy) begin
        rem  <= fits ? (shifted - {1'b0, dvs}) : shifted;
        quo  <= {quo[QW-2:0], fits};
        left <= left - 1'b1;
        if (left == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rr_control.sv
`timescale 1ns/1ps
module rr_control
  import rr_pkg::*;
#(
  parameter int DIV_W    = 30,
  parameter int RATE_NUM = 1_000_000_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             inValid,
  input  logic [DIV_W-1:0] divIn,
  output ctl_t             ctl,
  output logic [DIV_W-1:0] nCur,
  output logic [DIV_W-1:0] rateDeciHz
);
  logic [DIV_W-1:0] cnt, nReq, rateQ;
  logic             rateStart, rateBusy, rateDone;

  assign nReq = (divIn == '0) ? DIV_W'(1) : divIn;

  always_comb begin
    ctl.clear  = clear;
    ctl.accept = inValid && !clear;
    ctl.first  = ctl.accept && (cnt == '0);
    ctl.last   = ctl.accept && (cnt == nCur - 1'b1);
  end

  assign rateStart = clear || (ctl.last && (nReq != nCur));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      nCur <= DIV_W'(1);
    end else if (clear || ctl.last) begin
      cnt  <= '0;
      nCur <= nReq;
    end else if (ctl.accept) begin
      cnt  <= cnt + 1'b1;
    end
  end

  rr_divider #(.ND(DIV_W), .NV(DIV_W), .QW(DIV_W)) u_rateDiv (
    .clk(clk), .rstN(rstN), .abort(1'b0), .start(rateStart),
    .dividend(DIV_W'(RATE_NUM)), .divisor(nReq),
    .busy(rateBusy), .done(rateDone), .quotient(rateQ)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rateDeciHz <= DIV_W'(RATE_NUM);
    else if (rateDone) rateDeciHz <= rateQ;
  end

  logic unusedBusy;
  assign unusedBusy = rateBusy;
endmodule

// File: rtl/rr_datapath.sv
`timescale 1ns/1ps
module rr_datapath
  import rr_pkg::*;
#(
  parameter int W     = 12,
  parameter int DIV_W = 30
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctl_t                ctl,
  input  logic [DIV_W-1:0]    nCur,
  input  logic [1:0]          modeIn,
  input  logic signed [W-1:0] sample,
  input  logic                take,
  output logic                valid,
  output logic signed [W-1:0] lo,
  output logic signed [W-1:0] hi,
  output logic                overflow
);
  localparam int AW = W + DIV_W;

  logic [1:0]           modeCur;
  logic signed [AW-1:0] acc, sumNow;
  logic [AW-1:0]        sumAbs;
  logic signed [W-1:0]  minR, maxR, minNow, maxNow, directLo, directHi, meanVal;
  logic [W-1:0]         quo;
  logic                 negR, pending, divBusy, divDone;
  logic                 meanBlock, divStart, meanLost, direct, produce, lost;

  assign sumNow = (ctl.first ? '0 : acc) + AW'(sample);
  assign sumAbs = sumNow[AW-1] ? AW'(-sumNow) : AW'(sumNow);
  assign minNow = (ctl.first || sample < minR) ? sample : minR;
  assign maxNow = (ctl.first || sample > maxR) ? sample : maxR;

  assign meanBlock = ctl.last && (modeCur == MODE_MEAN) && (nCur != DIV_W'(1));
  assign divStart  = meanBlock && !divBusy;
  assign meanLost  = meanBlock && divBusy;
  assign direct    = ctl.last && !meanBlock;
  assign produce   = direct || divDone;
  assign lost      = meanLost || (direct && divDone);

  assign directLo = (modeCur == MODE_EXTREME) ? minNow : sample;
  assign directHi = (modeCur == MODE_EXTREME) ? maxNow : sample;
  assign meanVal  = negR ? -$signed(quo) : $signed(quo);

  rr_divider #(.ND(AW), .NV(DIV_W), .QW(W)) u_meanDiv (
    .clk(clk), .rstN(rstN), .abort(ctl.clear), .start(divStart),
    .dividend(sumAbs), .divisor(nCur),
    .busy(divBusy), .done(divDone), .quotient(quo)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeCur <= MODE_KEEP; acc <= '0; minR <= '0; maxR <= '0; negR <= 1'b0;
      valid <= 1'b0; lo <= '0; hi <= '0; pending <= 1'b0; overflow <= 1'b0;
    end else if (ctl.clear) begin
      modeCur  <= modeIn;
      valid    <= 1'b0;
      pending  <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (ctl.accept) begin
        acc  <= sumNow;
        minR <= minNow;
        maxR <= maxNow;
      end
      if (ctl.last) modeCur <= modeIn;
      if (divStart) negR <= sumNow[AW-1];
      valid <= produce;
      if (direct) begin
        lo <= directLo; hi <= directHi;
      end else if (divDone) begin
        lo <= meanVal;  hi <= meanVal;
      end
      pending <= produce || (pending && !take);
      if ((produce && pending && !take) || lost) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/rate_reducer.sv
`timescale 1ns/1ps
module rate_reducer
  import rr_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int SAMPLE_W = 12,
  parameter int DIV_W    = 30,
  parameter int RATE_NUM = 1_000_000_000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         clear,
  input  logic [DIV_W-1:0]             divIn,
  input  logic [2*NUM_CH-1:0]          modeIn,
  input  logic                         inValid,
  input  logic [NUM_CH*SAMPLE_W-1:0]   inSample,
  input  logic [NUM_CH-1:0]            outTake,
  output logic [NUM_CH-1:0]            outValid,
  output logic [NUM_CH*SAMPLE_W-1:0]   outLo,
  output logic [NUM_CH*SAMPLE_W-1:0]   outHi,
  output logic [NUM_CH-1:0]            overflow,
  output logic [DIV_W-1:0]             rateDeciHz
);
  ctl_t             ctl;
  logic [DIV_W-1:0] nCur;

  rr_control #(.DIV_W(DIV_W), .RATE_NUM(RATE_NUM)) u_ctrl (
    .clk(clk), .rstN(rstN), .clear(clear), .inValid(inValid), .divIn(divIn),
    .ctl(ctl), .nCur(nCur), .rateDeciHz(rateDeciHz)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    rr_datapath #(.W(SAMPLE_W), .DIV_W(DIV_W)) u_dp (
      .clk(clk), .rstN(rstN), .ctl(ctl), .nCur(nCur),
      .modeIn(modeIn[2*c +: 2]),
      .sample(inSample[c*SAMPLE_W +: SAMPLE_W]),
      .take(outTake[c]),
      .valid(outValid[c]),
      .lo(outLo[c*SAMPLE_W +: SAMPLE_W]),
      .hi(outHi[c*SAMPLE_W +: SAMPLE_W]),
      .overflow(overflow[c])
    );
  end
endmodule

// File: rtl/rr_checker.sv
`timescale 1ns/1ps
module rr_checker #(
  parameter int NUM_CH   = 2,
  parameter int W        = 12,
  parameter int DIV_W    = 30,
  parameter int RATE_NUM = 1_000_000_000
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  clear,
  input logic [NUM_CH-1:0]     outValid,
  input logic [NUM_CH*W-1:0]   outLo,
  input logic [NUM_CH*W-1:0]   outHi,
  input logic [NUM_CH-1:0]     overflow,
  input logic [DIV_W-1:0]      rateDeciHz
);
  // R9
  rate_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rateDeciHz != '0) && (rateDeciHz <= DIV_W'(RATE_NUM)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R4
    lo_le_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
      outValid[c] |-> ($signed(outLo[c*W +: W]) <= $signed(outHi[c*W +: W])));
    // R8
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      (overflow[c] && !clear) |=> overflow[c]);
    // R6
    clear_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      clear |=> !outValid[c]);
  end
endmodule

bind rate_reducer rr_checker #(
  .NUM_CH(NUM_CH), .W(SAMPLE_W), .DIV_W(DIV_W), .RATE_NUM(RATE_NUM)
) u_chk (
  .clk(clk), .rstN(rstN), .clear(clear), .outValid(outValid),
  .outLo(outLo), .outHi(outHi), .overflow(overflow), .rateDeciHz(rateDeciHz)
);

// File: tb/rate_reducer_bench.sv
`timescale 1ns/1ps
module rate_reducer_bench;
  localparam int NC = 2;
  localparam int W  = 12;
  localparam int DW = 30;
  localparam int RN = 1_000_000_000;

  logic clk = 1'b0, rstN = 1'b0, clear = 1'b0, inValid = 1'b0;
  logic [DW-1:0]   divIn = '0;
  logic [2*NC-1:0] modeIn = '0;
  logic [NC*W-1:0] inSample = '0;
  logic [NC-1:0]   outTake = '1;
  logic [NC-1:0]   outValid, overflow;
  logic [NC*W-1:0] outLo, outHi;
  logic [DW-1:0]   rateDeciHz;

  always #2.5 clk = ~clk;

  rate_reducer #(.NUM_CH(NC), .SAMPLE_W(W), .DIV_W(DW), .RATE_NUM(RN)) u_rate_reducer (
    .clk(clk), .rstN(rstN), .clear(clear), .divIn(divIn), .modeIn(modeIn),
    .inValid(inValid), .inSample(inSample), .outTake(outTake), .outValid(outValid),
    .outLo(outLo), .outHi(outHi), .overflow(overflow), .rateDeciHz(rateDeciHz)
  );

  typedef struct { int lo; int hi; int req; } exp_t;
  exp_t expQ[NC][$];
  int   blk[NC][$];
  int   mMode[NC];
  longint mN = 1;
  longint mCnt = 0;
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  function automatic longint effN(input logic [DW-1:0] d);
    return (d == 0) ? 1 : longint'(d);
  endfunction

  task automatic chk(input bit ok, input int req, input string what, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic checkOut();
    for (int c = 0; c < NC; c++) begin
      if (outValid[c]) begin
        if (expQ[c].size() == 0) begin
          chk(1'b0, 1, "unexpected result strobe", 1, 0);  // R1
        end else begin
          exp_t e = expQ[c].pop_front();
          int lo = $signed(outLo[c*W +: W]);
          int hi = $signed(outHi[c*W +: W]);
          chk(lo == e.lo, e.req, "low half", lo, e.lo);
          chk(hi == e.hi, e.req, "high half", hi, e.hi);
        end
      end
    end
  endtask

  function automatic void closeBlock(input int c);
    exp_t e;
    longint sum = 0;
    int mn = blk[c][0], mx = blk[c][0];
    foreach (blk[c][i]) begin
      sum += blk[c][i];
      if (blk[c][i] < mn) mn = blk[c][i];
      if (blk[c][i] > mx) mx = blk[c][i];
    end
    if (mMode[c] == 1) begin e.lo = int'(sum / mN); e.hi = e.lo; e.req = 3; end       // R3
    else if (mMode[c] == 2) begin e.lo = mn; e.hi = mx; e.req = 4; end               // R4
    else begin e.lo = blk[c][$]; e.hi = e.lo; e.req = 2; end                         // R2
    expQ[c].push_back(e);
    blk[c].delete();
  endfunction

  task automatic cyc(input bit v, input int s0, input int s1, input bit clr);
    @(negedge clk);
    checkOut();
    inValid  = v;
    clear    = clr;
    inSample = {s1[W-1:0], s0[W-1:0]};
    if (clr) begin  // R6: settings load now, partial block and same-cycle sample dropped
      mCnt = 0; mN = effN(divIn);
      for (int c = 0; c < NC; c++) begin
        mMode[c] = int'(modeIn[2*c +: 2]); blk[c].delete(); expQ[c].delete();
      end
    end else if (v) begin
      blk[0].push_back(s0); blk[1].push_back(s1);
      mCnt++;
      if (mCnt == mN) begin
        for (int c = 0; c < NC; c++) closeBlock(c);
        mCnt = 0; mN = effN(divIn);
        for (int c = 0; c < NC; c++) mMode[c] = int'(modeIn[2*c +: 2]);
      end
    end
  endtask

  function automatic int rnd();
    return int'($urandom_range(4095)) - 2048;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, 1'b0);
  endtask

  task automatic drainCheck(input int req);
    for (int c = 0; c < NC; c++) chk(expQ[c].size() == 0, req, "missing results", expQ[c].size(), 0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) mMode[c] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(outValid == 0, 10, "valid after reset", outValid, 0);
    chk(overflow == 0, 10, "overflow after reset", overflow, 0);
    chk(rateDeciHz == RN, 10, "rate after reset", rateDeciHz, RN);

    // R1 R2 R4 R5: ch0 keep, ch1 extremes, N=4, mixed gaps
    divIn = 4; modeIn = {2'd2, 2'd0};
    cyc(1'b0, 0, 0, 1'b1);
    for (int i = 0; i < 24; i++) cyc((i % 5) != 3, rnd(), rnd(), 1'b0);
    idle(3); drainCheck(1);

    // R1: divisor 0 behaves as 1; ch0 code 3 (keep), ch1 mean bypass (R3)
    divIn = 0; modeIn = {2'd1, 2'd3};
    cyc(1'b0, 0, 0, 1'b1);
    for (int i = 0; i < 8; i++) cyc(i != 4, rnd(), rnd(), 1'b0);
    idle(2); drainCheck(1);
    idle(40);
    chk(rateDeciHz == RN, 9, "rate N=0", rateDeciHz, RN);  // R9

    // R9 other divisors
    divIn = 3; cyc(1'b0, 0, 0, 1'b1); idle(40);
    chk(rateDeciHz == RN / 3, 9, "rate N=3", rateDeciHz, RN / 3);
    divIn = DW'(RN); cyc(1'b0, 0, 0, 1'b1); idle(40);
    chk(rateDeciHz == 1, 9, "rate N=max", rateDeciHz, 1);

    // R3 R7: ch0 mean, ch1 extremes, N=16, back-to-back blocks
    divIn = 16; modeIn = {2'd2, 2'd1};
    cyc(1'b0, 0, 0, 1'b1);
    for (int i = 0; i < 48; i++) cyc(1'b1, rnd(), rnd(), 1'b0);
    for (int i = 0; i < 16; i++) cyc(1'b1, -2048, 2047, 1'b0);
    for (int i = 0; i < 16; i++) cyc(1'b1, (i < 8) ? -3 : 2, -1, 1'b0);
    idle(25); drainCheck(3);

    // R6: mid-block changes apply at next boundary; clear with valid drops sample
    divIn = 5; modeIn = {2'd0, 2'd2};
    cyc(1'b0, 0, 0, 1'b1);
    for (int i = 0; i < 2; i++) cyc(1'b1, rnd(), rnd(), 1'b0);
    divIn = 3; modeIn = {2'd2, 2'd0};
    for (int i = 0; i < 12; i++) cyc(1'b1, rnd(), rnd(), 1'b0);
    cyc(1'b1, 1, 1, 1'b0);
    cyc(1'b1, 77, 77, 1'b1);
    cyc(1'b0, 0, 0, 1'b0);
    chk(outValid == 0, 6, "valid after clear", outValid, 0);
    for (int i = 0; i < 6; i++) cyc(1'b1, rnd(), rnd(), 1'b0);
    idle(3); drainCheck(6);

    // R8: results not taken raise sticky overflow, clear releases it
    divIn = 1; modeIn = 4'b0000;
    cyc(1'b0, 0, 0, 1'b1);
    outTake = '0;
    cyc(1'b1, 5, 6, 1'b0);
    cyc(1'b1, 7, 8, 1'b0);
    idle(2);
    chk(overflow == 2'b11, 8, "overflow set", overflow, 3);
    outTake = '1;
    idle(2);
    chk(overflow == 2'b11, 8, "overflow held", overflow, 3);
    cyc(1'b0, 0, 0, 1'b1);
    idle(1);
    chk(overflow == 2'b00, 8, "overflow cleared", overflow, 0);
    drainCheck(8);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule